// File: doc/BRIEF.md
# Eight-Channel Bus-Clocked PWM Timer

The block provides eight independent pulse-width modulators behind a simple APB-style register port. Every channel owns a free-running up-counter clocked by the bus clock, a duty threshold, a period length and a control word. The counter steps through the values 0 to period−1 and then starts over. The channel drives its output pin low, which is the active level, while the count is below the duty threshold, and drives it high for the rest of the period. A separate per-channel output-enable tells the pad whether the pin is driven at all.

Software programs a channel by writing its period and duty and then setting the run and drive bits. Several optional behaviours are available. A one-shot mode stops the channel after a single period. A hold bit pins the counter at zero. Each channel also has a sticky end-of-period flag, which raises an interrupt line when its mask bit is set. The eight channels are split into two banks of four, and the upper bank sits 0x8000 above the lower one.

Top module: `pwm_bank_apb`

## Requirements
- R1: After reset every register reads zero, every `pwm_oe` bit and every `irq` bit is 0, and every `pwm_n` bit is 1.
- R2: The register address is decoded as follows. Bit 15 selects the bank. Bits 5:4 select the channel within the bank, so the channel index is {bit 15, bits 5:4}. Bits 3:2 select the register: 0 is the counter, 1 is the duty threshold, 2 is the period length and 3 is the control word. An address with any of bits 14:6 set hits nothing: it reads as zero and a write to it is dropped.
- R3: While control bit 0 (run) is clear and no bus write targets the channel, the counter keeps its value.
- R4: While the channel runs, the counter takes the values 0 through period−1 in turn and returns to 0 on the clock after it reaches period−1. A period of 0 or 1 keeps the counter at 0.
- R5: While control bit 3 (drive) is set, `pwm_n` is low exactly when the counter is below the duty threshold, and high otherwise.
- R6: A duty threshold of zero keeps the pin high for the whole period. A duty threshold at or above the period length keeps the pin low for the whole period.
- R7: `pwm_oe` follows control bit 3. While that bit is clear, `pwm_n` sits high.
- R8: A bus write to the counter register loads the written value on that clock. Writing zero therefore restarts the current period from its first cycle.
- R9: With control bit 4 (one-shot) set, the end of a period returns the counter to 0 and clears the run bit, so the channel stops.
- R10: Control bit 6 is the end-of-period flag. The hardware sets it at every period end, and it stays set until software writes a 0 to it. Writing a 1 to it leaves it unchanged. The `irq` output is this flag ANDed with control bit 5 (interrupt mask).
- R11: While control bit 7 (hold) is set, the counter is forced to 0 on every clock. This takes priority over run and over counter writes.
- R12: Control bits 1, 2 and 8 are stored and read back, but they have no effect on counting or on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which also advances every counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 16 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high and `pwrite` is low |
| pwm_n | output | 8 | Active-low PWM pin value per channel |
| pwm_oe | output | 8 | Pin drive enable per channel |
| irq | output | 8 | Masked end-of-period interrupt per channel |

## Verification
The bench probes the wrap point with off-by-one periods. A counter that ran one cycle past period−1 would stretch the high phase and would shift every later sample of the waveform. The duty extremes (zero, equal to the period, above the period) catch a compare that is inclusive or that wraps. The one-shot run catches a channel that keeps counting, or one that stops somewhere other than zero. Aliasing addresses with stray bits set would overwrite channel 0 if the decode ignored the upper address bits. Software writing a 1 to the flag, or a 0 to it, catches a flag that can be forced on, or one that cannot be cleared. A counter write taking effect one cycle late would show up as a constant phase offset after the restart.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // control word layout; bit positions are decoded by software
    localparam int CTRL_W = 9;
    localparam int B_RUN   = 0;
    localparam int B_XCLK  = 1;  // stored only
    localparam int B_NEDGE = 2;  // stored only
    localparam int B_DRIVE = 3;
    localparam int B_ONCE  = 4;
    localparam int B_IMASK = 5;
    localparam int B_FLAG  = 6;
    localparam int B_HOLD  = 7;
    localparam int B_CAPT  = 8;  // stored only

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_PER  = 2'd2,
        SEL_CTRL = 2'd3
    } regsel_e;

endpackage

// File: rtl/pwmt_decode.sv
module pwmt_decode
    import pwmt_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_BIT    = 15,
    parameter int CH_PER_BANK = 4,
    parameter int NUM_BANKS   = 2
) (
    input  logic [ADDR_W-1:0]                                  addr,
    output logic                                               hit,
    output logic [$clog2(NUM_BANKS)+$clog2(CH_PER_BANK)-1:0]   ch_idx,
    output regsel_e                                            sel
);
    localparam int CH_BITS   = $clog2(CH_PER_BANK);
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((1 << (4 + CH_BITS)) - 1);
    localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'(((1 << BANK_BITS) - 1) << BANK_BIT);
    localparam logic [ADDR_W-1:0] USED_MASK = LOW_MASK | BANK_MASK;

    always_comb begin
        hit    = ((addr & ~USED_MASK) == '0);
        ch_idx = {addr[BANK_BIT +: BANK_BITS], addr[4 +: CH_BITS]};
        sel    = regsel_e'(addr[3:2]);
    end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  regsel_e           wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              pwm_n_o,
    output logic              oe_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  duty;
        logic [CNT_W-1:0]  period;
        logic [CTRL_W-1:0] ctrl;
    } chan_t;

    chan_t          st_d, st_q;
    logic [CNT_W:0] cnt_inc;
    logic           last_tick;
    logic           cnt_wr;
    logic           period_end;

    always_comb begin
        st_d       = st_q;
        cnt_inc    = {1'b0, st_q.cnt} + 1'b1;
        last_tick  = (cnt_inc >= {1'b0, st_q.period});
        cnt_wr     = wr_en && (wr_sel == SEL_CNT);
        period_end = st_q.ctrl[B_RUN] && !st_q.ctrl[B_HOLD] && !cnt_wr && last_tick;

        if (wr_en) begin
            unique case (wr_sel)
                SEL_DUTY: st_d.duty   = wr_data[CNT_W-1:0];
                SEL_PER:  st_d.period = wr_data[CNT_W-1:0];
                SEL_CTRL: begin
                    st_d.ctrl         = wr_data[CTRL_W-1:0];
                    st_d.ctrl[B_FLAG] = st_q.ctrl[B_FLAG] & wr_data[B_FLAG];
                end
                default: ;
            endcase
        end

        if (st_q.ctrl[B_HOLD]) begin
            st_d.cnt = '0;
        end else if (cnt_wr) begin
            st_d.cnt = wr_data[CNT_W-1:0];
        end else if (st_q.ctrl[B_RUN]) begin
            st_d.cnt = last_tick ? '0 : cnt_inc[CNT_W-1:0];
        end

        if (period_end) begin
            st_d.ctrl[B_FLAG] = 1'b1;
            if (st_q.ctrl[B_ONCE]) begin
                st_d.ctrl[B_RUN] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign duty_o   = st_q.duty;
    assign period_o = st_q.period;
    assign ctrl_o   = st_q.ctrl;
    assign oe_o     = st_q.ctrl[B_DRIVE];
    assign pwm_n_o  = !(st_q.ctrl[B_DRIVE] && (st_q.cnt < st_q.duty));
    assign irq_o    = st_q.ctrl[B_FLAG] & st_q.ctrl[B_IMASK];
endmodule

// File: rtl/pwm_bank_apb.sv
module pwm_bank_apb
    import pwmt_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int CH_PER_BANK = 4,
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 16,
    parameter int BANK_BIT    = 15,
    parameter int DATA_W      = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             psel,
    input  logic                             penable,
    input  logic                             pwrite,
    input  logic [ADDR_W-1:0]                paddr,
    input  logic [DATA_W-1:0]                pwdata,
    output logic [DATA_W-1:0]                prdata,
    output logic [NUM_BANKS*CH_PER_BANK-1:0] pwm_n,
    output logic [NUM_BANKS*CH_PER_BANK-1:0] pwm_oe,
    output logic [NUM_BANKS*CH_PER_BANK-1:0] irq
);
    localparam int NUM_CH = NUM_BANKS * CH_PER_BANK;
    localparam int IDX_W  = $clog2(NUM_BANKS) + $clog2(CH_PER_BANK);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    regsel_e           sel;
    logic              wr_stb;
    logic [NUM_CH-1:0] ch_wr;

    logic [CNT_W-1:0]  cnt_all    [NUM_CH];
    logic [CNT_W-1:0]  duty_all   [NUM_CH];
    logic [CNT_W-1:0]  period_all [NUM_CH];
    logic [CTRL_W-1:0] ctrl_all   [NUM_CH];

    pwmt_decode #(
        .ADDR_W      (ADDR_W),
        .BANK_BIT    (BANK_BIT),
        .CH_PER_BANK (CH_PER_BANK),
        .NUM_BANKS   (NUM_BANKS)
    ) u_dec (
        .addr   (paddr),
        .hit    (hit),
        .ch_idx (idx),
        .sel    (sel)
    );

    assign wr_stb = psel && penable && pwrite && hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_wr[g] = wr_stb && (idx == IDX_W'(g));

        pwmt_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr[g]),
            .wr_sel   (sel),
            .wr_data  (pwdata),
            .cnt_o    (cnt_all[g]),
            .duty_o   (duty_all[g]),
            .period_o (period_all[g]),
            .ctrl_o   (ctrl_all[g]),
            .pwm_n_o  (pwm_n[g]),
            .oe_o     (pwm_oe[g]),
            .irq_o    (irq[g])
        );
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && hit) begin
            unique case (sel)
                SEL_CNT:  prdata = DATA_W'(cnt_all[idx]);
                SEL_DUTY: prdata = DATA_W'(duty_all[idx]);
                SEL_PER:  prdata = DATA_W'(period_all[idx]);
                SEL_CTRL: prdata = DATA_W'(ctrl_all[idx]);
                default:  prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_wr,
    input logic [CNT_W-1:0]  cnt    [NUM_CH],
    input logic [CNT_W-1:0]  duty   [NUM_CH],
    input logic [CNT_W-1:0]  period [NUM_CH],
    input logic [CTRL_W-1:0] ctrl   [NUM_CH],
    input logic [NUM_CH-1:0] pwm_n,
    input logic [NUM_CH-1:0] pwm_oe
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[g][B_RUN] && !ctrl[g][B_HOLD] && !ch_wr[g]) |=> $stable(cnt[g]));

        a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[g][B_RUN] && !ch_wr[g] && (cnt[g] < period[g])) |=> (cnt[g] < period[g]));

        a_r5_active_low: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_oe[g] && (cnt[g] < duty[g])) |-> !pwm_n[g]);

        a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_oe[g] |-> pwm_n[g]);

        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[g][B_FLAG] && !ch_wr[g]) |=> ctrl[g][B_FLAG]);

        a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl[g][B_HOLD] |=> (cnt[g] == '0));
    end
endmodule

bind pwm_bank_apb pwmt_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ch_wr  (ch_wr),
    .cnt    (cnt_all),
    .duty   (duty_all),
    .period (period_all),
    .ctrl   (ctrl_all),
    .pwm_n  (pwm_n),
    .pwm_oe (pwm_oe)
);

// File: tb/sim_pwm_bank_apb.sv
`timescale 1ns/1ps
module sim_pwm_bank_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  pwm_n, pwm_oe, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank_apb u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pwm_n(pwm_n), .pwm_oe(pwm_oe), .irq(irq)
    );

    // table: write enable, address, write data, expected read-back at same address
    localparam int NV = 11;
    localparam logic        V_WR  [NV] = '{1, 1, 1, 0, 1, 1, 1, 0, 1, 0, 1};
    localparam logic [15:0] V_AD  [NV] = '{16'h0004, 16'h0018, 16'h8024, 16'h0024, 16'h803C,
                                           16'h000C, 16'h0044, 16'h0004, 16'h4004, 16'h0004,
                                           16'h0030};
    localparam logic [31:0] V_WD  [NV] = '{32'h11, 32'h22, 32'h33, 32'h0, 32'h106,
                                           32'h40, 32'hFF, 32'h0, 32'h55, 32'h0, 32'h7};
    localparam logic [31:0] V_EX  [NV] = '{32'h11, 32'h22, 32'h33, 32'h0, 32'h106,
                                           32'h0, 32'h0, 32'h11, 32'h0, 32'h11, 32'h7};
    // rows: 0-3 R2 map, 4 R12 stored bits, 5 R10 flag not settable,
    //       6-9 R2 stray address bits, 10 R3 counter holds while stopped

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    // k-th sample after a write returns: expect low while (k mod per) < dty
    task automatic wave(input int n, input int per, input int dty, input string tag);
        for (int k = 0; k < n; k++) begin
            #1 chk(tag, {31'b0, pwm_n[0]}, ((k % per) < dty) ? 32'd0 : 32'd1);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] rd, rd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 pwm_oe", {24'b0, pwm_oe}, 32'h0);
        chk("R1 irq", {24'b0, irq}, 32'h0);
        chk("R1 pwm_n", {24'b0, pwm_n}, 32'hFF);
        bus_rd(16'h000C, rd); chk("R1 ctrl ch0", rd, 32'h0);
        bus_rd(16'h8018, rd); chk("R1 period ch5", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) bus_wr(V_AD[i], V_WD[i]);
            bus_rd(V_AD[i], rd);
            chk($sformatf("table row %0d (R2/R3/R10/R12)", i), rd, V_EX[i]);
        end

        // R4 R5 R12: period 5, duty 2, run+drive plus inert bits 1,2,8
        bus_wr(16'h0008, 32'd5);
        bus_wr(16'h0004, 32'd2);
        bus_wr(16'h000C, 32'h10F);
        wave(12, 5, 2, "R4/R5/R12 waveform");
        chk("R7 oe on", {31'b0, pwm_oe[0]}, 32'd1);
        chk("R10 masked irq", {31'b0, irq[0]}, 32'd0);

        // R6 duty extremes
        bus_wr(16'h0008, 32'd6);
        bus_wr(16'h0004, 32'd0);
        wave(8, 6, 0, "R6 duty zero");
        bus_wr(16'h0004, 32'd6);
        wave(8, 6, 6, "R6 duty equal period");
        bus_wr(16'h0004, 32'd9);
        wave(8, 6, 9, "R6 duty above period");

        // R7 drive off
        bus_wr(16'h000C, 32'h001);
        #1 chk("R7 oe off", {31'b0, pwm_oe[0]}, 32'd0);
        chk("R7 pin high", {31'b0, pwm_n[0]}, 32'd1);

        // R11 hold
        bus_wr(16'h000C, 32'h081);
        bus_rd(16'h0000, rd); chk("R11 held at zero", rd, 32'd0);
        bus_wr(16'h000C, 32'h001);
        bus_rd(16'h0000, rd); chk("R11 released counts", rd, 32'd2);

        // R8 restart by writing zero
        bus_wr(16'h0008, 32'd10);
        bus_wr(16'h0004, 32'd3);
        bus_wr(16'h000C, 32'h009);
        repeat (7) @(negedge clk);
        bus_wr(16'h0000, 32'd0);
        wave(12, 10, 3, "R8 restart phase");

        // R10 flag sticky, masked, cleared by writing 0
        bus_wr(16'h000C, 32'h068);
        #1 chk("R10 irq set", {31'b0, irq[0]}, 32'd1);
        repeat (4) @(negedge clk);
        #1 chk("R10 irq sticky", {31'b0, irq[0]}, 32'd1);
        bus_wr(16'h000C, 32'h028);
        #1 chk("R10 irq cleared", {31'b0, irq[0]}, 32'd0);
        bus_rd(16'h000C, rd); chk("R10 ctrl after clear", rd, 32'h028);

        // R3 stopped counter keeps its value
        bus_rd(16'h0000, rd);
        repeat (5) @(negedge clk);
        bus_rd(16'h0000, rd2); chk("R3 counter frozen", rd2, rd);

        // R9 one-shot: period 4 duty 2
        bus_wr(16'h0000, 32'd0);
        bus_wr(16'h0008, 32'd4);
        bus_wr(16'h0004, 32'd2);
        bus_wr(16'h000C, 32'h019);
        for (int k = 0; k < 10; k++) begin
            #1 chk("R9 one-shot waveform", {31'b0, pwm_n[0]},
                   (k < 2 || k >= 4) ? 32'd0 : 32'd1);
            @(negedge clk);
        end
        bus_rd(16'h000C, rd); chk("R9 run cleared, flag set", rd, 32'h058);
        bus_rd(16'h0000, rd); chk("R9 stopped at zero", rd, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule